// File: doc/BRIEF.md
# Power-Management Event Register Window with SCI

This block holds the power-management event state of a system controller. Software reaches it through a 64-byte I/O window. The base of the window comes from a configuration value, and a configuration enable bit turns the window on or off. Inside the window there are three 16-bit registers:

- an event status register;
- an event enable register;
- a control register.

The window also gives dword read access to a free-running power-management timer.

External one-cycle pulses set the status bits for the RTC alarm, the power button and the global lock. The timer sets its own status bit each time its top bit changes value. The block drives a level interrupt, `sci_o`. It is high whenever one of those four event bits is both set in status and set in enable. Software acknowledges an event by writing 1 to its status bit.

Each I/O access is qualified by byte enables that give its size:

- `4'b0011` is a 16-bit access, with the data on bits [15:0];
- `4'b1111` is a 32-bit access.

Reads are combinational from the current register state. Writes take effect at the next rising clock edge.

Top module: `pm_evt_ctrl`

## Requirements
- R1: After reset, the status, enable and control registers read 0, the timer restarts from 0, and `sci_o` is low.
- R2: An access hits the window only when `cfg_ctl_i[0]` is 1 and `io_addr_i[15:6]` equals `cfg_base_i[15:6]`, which is the base masked with 0xFFC0. An access that does not hit reads 0 and changes no register.
- R3: Inside the window, `io_addr_i[3:0]` selects the register, so the four 16-byte quarters alias each other (base+0x12 reaches the enable register).
- R4: A 16-bit access (`io_be_i` = 4'b0011) at offset 0x02 reads and writes the enable register. The same access at offset 0x04 reads and writes the control register. All 16 bits of both registers are stored.
- R5: A 16-bit write at offset 0x00 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. Only bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) are implemented; the other status bits always read 0.
- R6: A one-cycle pulse on `gbl_evt_i`, `pwrbtn_evt_i` or `rtc_evt_i` sets status bit 5, 8 or 10 respectively at the next edge. If the pulse arrives in the same cycle as a write that clears the same bit, the bit is set.
- R7: A 32-bit read (`io_be_i` = 4'b1111) at offset 0x08 returns the timer value, zero-extended to 32 bits. The timer counts up by one every clock and wraps modulo 2^TMR_W.
- R8: Status bit 0 is set at the clock edge on which the timer's top bit changes value, both on the 0-to-1 change and on the wrap back to 0.
- R9: The following read 0: offsets 0x06, 0x0A to 0x0F, a 32-bit read at a word register, and a 16-bit read at 0x08. A 32-bit write changes nothing.
- R10: `sci_o` is high exactly when status AND enable AND 0x0521 is nonzero. Enable bits outside that mask never raise it. It changes in the cycle after the status or enable write, or the event, that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 32 | Window base from configuration; only bits [15:6] are used |
| cfg_ctl_i | input | 8 | Configuration control byte; bit 0 enables decoding |
| io_addr_i | input | 16 | I/O byte address |
| io_be_i | input | 4 | Byte enables giving the access size |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 32 | Write data, right-aligned |
| io_rdata_o | output | 32 | Read data, 0 when nothing is selected |
| gbl_evt_i | input | 1 | Global-lock event pulse |
| pwrbtn_evt_i | input | 1 | Power-button event pulse |
| rtc_evt_i | input | 1 | RTC alarm event pulse |
| sci_o | output | 1 | Level interrupt output |

## Verification
The bench covers three kinds of internal error. A status bit that sticks shows on `sci_o` in the cycle after its enable is written. A status bit that is cleared wrongly shows on the very next status read. A write that lands in the wrong register is caught because every register is read back right after each write.

The timer status is checked on both sides of the edge on which the top bit changes: one clock before that edge it must still be 0, and at the edge it must be 1. An off-by-one in the detection of the change is therefore seen within a single cycle. Window decode faults are exposed by two kinds of access: a write from outside the window, and a write with the enable bit clear. Each one is followed by a read-back of the register it could have changed.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_STS = 4'h0;
  localparam logic [OFF_W-1:0] OFF_EN  = 4'h2;
  localparam logic [OFF_W-1:0] OFF_CTL = 4'h4;
  localparam logic [OFF_W-1:0] OFF_TMR = 4'h8;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  // implemented status bits are exactly the interrupt sources
  localparam logic [15:0] SCI_MASK = 16'h0521;

  localparam logic [3:0] BE_WORD  = 4'b0011;
  localparam logic [3:0] BE_DWORD = 4'b1111;

  typedef enum logic [2:0] {RD_NONE, RD_STS, RD_EN, RD_CTL, RD_TMR} rd_sel_e;
endpackage

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_base_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_sts_o,
  output logic              wr_en_o,
  output logic              wr_ctl_o,
  output rd_sel_e           rd_sel_o
);
  logic             hit, word_acc, dword_acc;
  logic [OFF_W-1:0] off;
  logic             unused_base;

  assign hit       = cfg_en_i && (addr_i[ADDR_W-1:WIN_BITS] == cfg_base_i[ADDR_W-1:WIN_BITS]);
  assign off       = addr_i[OFF_W-1:0];
  assign word_acc  = (be_i == BE_WORD);
  assign dword_acc = (be_i == BE_DWORD);
  assign unused_base = ^{cfg_base_i[31:ADDR_W], cfg_base_i[WIN_BITS-1:0],
                         addr_i[WIN_BITS-1:OFF_W]};

  always_comb begin
    wr_sts_o = 1'b0;
    wr_en_o  = 1'b0;
    wr_ctl_o = 1'b0;
    if (wr_i && hit && word_acc) begin
      wr_sts_o = (off == OFF_STS);
      wr_en_o  = (off == OFF_EN);
      wr_ctl_o = (off == OFF_CTL);
    end
  end

  always_comb begin
    rd_sel_o = RD_NONE;
    if (rd_i && hit) begin
      if (word_acc) begin
        case (off)
          OFF_STS: rd_sel_o = RD_STS;
          OFF_EN:  rd_sel_o = RD_EN;
          OFF_CTL: rd_sel_o = RD_CTL;
          default: rd_sel_o = RD_NONE;
        endcase
      end else if (dword_acc && off == OFF_TMR) begin
        rd_sel_o = RD_TMR;
      end
    end
  end

  // R3: at most one register strobe per access
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_sts_o, wr_en_o, wr_ctl_o}));
  // R9: dword writes reach no register
  a_r9_dword_wr_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_i == BE_DWORD) |-> !(wr_sts_o || wr_en_o || wr_ctl_o));
  // R2: no decode while disabled
  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |-> (rd_sel_o == RD_NONE && !wr_sts_o && !wr_en_o && !wr_ctl_o));
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TMR_W-1:0] cnt_o,
  output logic             flip_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  // top bit changes on the coming edge
  assign flip_o = &cnt_q[TMR_W-2:0];

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_flip_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_o |=> cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1]));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_sts_i,
  input  logic        wr_en_i,
  input  logic        wr_ctl_i,
  input  logic [15:0] wdata_i,
  input  logic        tmr_flip_i,
  input  logic        gbl_evt_i,
  input  logic        pwr_evt_i,
  input  logic        rtc_evt_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic [15:0] ctl_o,
  output logic        sci_o
);
  logic [15:0] sts_q, en_q, ctl_q;
  logic [15:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[BIT_TMR] = tmr_flip_i;
    set_vec[BIT_GBL] = gbl_evt_i;
    set_vec[BIT_PWR] = pwr_evt_i;
    set_vec[BIT_RTC] = rtc_evt_i;
  end
  assign clr_vec = wr_sts_i ? wdata_i : 16'h0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      // a new event outranks a same-cycle acknowledge
      sts_q <= ((sts_q & ~clr_vec) | set_vec) & SCI_MASK;
      if (wr_en_i)  en_q  <= wdata_i;
      if (wr_ctl_i) ctl_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;
  assign sci_o = |(sts_q & en_q & SCI_MASK);

  a_r5_w1c_tmr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && wdata_i[BIT_TMR] && !tmr_flip_i) |=> !sts_q[BIT_TMR]);
  a_r5_w0_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && !wdata_i[BIT_PWR] && sts_q[BIT_PWR]) |=> sts_q[BIT_PWR]);
  a_r6_evt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_evt_i |=> sts_q[BIT_PWR]);
  a_r8_tmr_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_flip_i |=> sts_q[BIT_TMR]);
  a_r2_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i || wr_ctl_i) |=> ($stable(en_q) && $stable(ctl_q)));
  a_r10_sci_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_o) |-> $past(wr_en_i || (|set_vec)));
  a_r10_sci_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sci_o) |-> $past(wr_sts_i || wr_en_i));
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6,
  parameter int TMR_W    = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_base_i,
  input  logic [7:0]        cfg_ctl_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [3:0]        io_be_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [31:0]       io_wdata_i,
  output logic [31:0]       io_rdata_o,
  input  logic              gbl_evt_i,
  input  logic              pwrbtn_evt_i,
  input  logic              rtc_evt_i,
  output logic              sci_o
);
  localparam int PAD_W = 32 - TMR_W;

  logic             wr_sts, wr_en, wr_ctl, tmr_flip;
  rd_sel_e          rd_sel;
  logic [TMR_W-1:0] tmr_cnt;
  logic [15:0]      sts, en, ctl;
  logic             unused_in;

  assign unused_in = ^{cfg_ctl_i[7:1], io_wdata_i[31:16]};

  pm_io_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
    .clk_i, .rst_ni,
    .cfg_base_i, .cfg_en_i(cfg_ctl_i[0]),
    .addr_i(io_addr_i), .be_i(io_be_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .wr_sts_o(wr_sts), .wr_en_o(wr_en), .wr_ctl_o(wr_ctl), .rd_sel_o(rd_sel)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .cnt_o(tmr_cnt), .flip_o(tmr_flip)
  );

  pm_evt_regs u_regs (
    .clk_i, .rst_ni,
    .wr_sts_i(wr_sts), .wr_en_i(wr_en), .wr_ctl_i(wr_ctl),
    .wdata_i(io_wdata_i[15:0]), .tmr_flip_i(tmr_flip),
    .gbl_evt_i, .pwr_evt_i(pwrbtn_evt_i), .rtc_evt_i,
    .sts_o(sts), .en_o(en), .ctl_o(ctl), .sci_o
  );

  always_comb begin
    case (rd_sel)
      RD_STS:  io_rdata_o = {16'h0000, sts};
      RD_EN:   io_rdata_o = {16'h0000, en};
      RD_CTL:  io_rdata_o = {16'h0000, ctl};
      RD_TMR:  io_rdata_o = {{PAD_W{1'b0}}, tmr_cnt};
      default: io_rdata_o = '0;
    endcase
  end

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 32'h0);
  a_r1_sci_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en & SCI_MASK) == 16'h0 |-> !sci_o);
endmodule

// File: tb/pm_evt_ctrl_test.sv
module pm_evt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12;
  localparam int HALF_SPAN = 1 << (TW - 1);
  localparam logic [15:0] BASE = 16'hEEC0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h0000_EEC5;
  logic [7:0]  cfg_ctl = 8'h01;
  logic [15:0] addr = '0;
  logic [3:0]  be = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        gbl = 1'b0, pwr = 1'b0, rtc = 1'b0;
  logic        sci;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_evt_ctrl #(.TMR_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_ctl_i(cfg_ctl),
    .io_addr_i(addr), .io_be_i(be), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata),
    .gbl_evt_i(gbl), .pwrbtn_evt_i(pwr), .rtc_evt_i(rtc), .sci_o(sci)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic chk_rd(string tag, logic [15:0] a, logic [3:0] b, logic [31:0] exp);
    logic [31:0] d;
    io_read(a, b, d);
    chk(tag, d, exp);
  endtask

  task automatic chk_rd_mask(string tag, logic [15:0] a, logic [31:0] m, logic [31:0] exp);
    logic [31:0] d;
    io_read(a, 4'b0011, d);
    chk(tag, d & m, exp);
  endtask

  task automatic chk_sci(string tag, logic exp);
    @(negedge clk); #1;
    chk(tag, {31'h0, sci}, {31'h0, exp});
  endtask

  task automatic t_reset;
    chk_rd("R1 sts", BASE + 16'h0, 4'b0011, 32'h0);
    chk_rd("R1 en", BASE + 16'h2, 4'b0011, 32'h0);
    chk_rd("R1 ctl", BASE + 16'h4, 4'b0011, 32'h0);
    chk_sci("R1 sci", 1'b0);
  endtask

  task automatic t_word_regs;
    io_write(BASE + 16'h2, 4'b0011, 32'hDEAD_A5C3);
    chk_rd("R4 en rw", BASE + 16'h2, 4'b0011, 32'h0000_A5C3);
    io_write(BASE + 16'h4, 4'b0011, 32'h0000_FFFF);
    chk_rd("R4 ctl rw", BASE + 16'h4, 4'b0011, 32'h0000_FFFF);
    chk_rd("R4 en kept", BASE + 16'h2, 4'b0011, 32'h0000_A5C3);
    io_write(BASE + 16'h2, 4'b0011, 32'h0);
  endtask

  task automatic t_decode;
    io_write(16'hEF04, 4'b0011, 32'h1234);
    chk_rd("R2 outside no write", BASE + 16'h4, 4'b0011, 32'h0000_FFFF);
    chk_rd("R2 outside reads 0", 16'hEF04, 4'b0011, 32'h0);
    cfg_ctl = 8'hFE;
    io_write(BASE + 16'h4, 4'b0011, 32'h0055);
    chk_rd("R2 disabled reads 0", BASE + 16'h4, 4'b0011, 32'h0);
    cfg_ctl = 8'h01;
    chk_rd("R2 disabled no write", BASE + 16'h4, 4'b0011, 32'h0000_FFFF);
    io_write(BASE + 16'h34, 4'b0011, 32'h0077);
    chk_rd("R3 alias ctl", BASE + 16'h4, 4'b0011, 32'h0000_0077);
    chk_rd("R3 alias en read", BASE + 16'h12, 4'b0011, 32'h0);
  endtask

  task automatic t_unmapped;
    io_write(BASE + 16'h2, 4'b1111, 32'hFFFF_FFFF);
    chk_rd("R9 dword write ignored", BASE + 16'h2, 4'b0011, 32'h0);
    chk_rd("R9 offset 6", BASE + 16'h6, 4'b0011, 32'h0);
    chk_rd("R9 offset C dword", BASE + 16'hC, 4'b1111, 32'h0);
    chk_rd("R9 dword at ctl", BASE + 16'h4, 4'b1111, 32'h0);
    chk_rd("R9 word at timer", BASE + 16'h8, 4'b0011, 32'h0);
  endtask

  task automatic t_events;
    // bit 0 may be set by the timer at any time here: mask it out
    io_write(BASE, 4'b0011, 32'hFFFF);
    @(negedge clk); pwr = 1'b1; @(posedge clk); #1 pwr = 1'b0;
    chk_rd_mask("R6 pwr sets bit8", BASE, 32'hFFFE, 32'h0100);
    chk_sci("R10 no sci without enable", 1'b0);
    io_write(BASE + 16'h2, 4'b0011, 32'h0100);
    chk_sci("R10 sci on enable", 1'b1);
    io_write(BASE, 4'b0011, 32'h0000);
    chk_rd_mask("R5 write 0 keeps", BASE, 32'hFFFE, 32'h0100);
    io_write(BASE, 4'b0011, 32'hFEFE);
    chk_rd_mask("R5 other ones keep bit8", BASE, 32'hFFFE, 32'h0100);
    io_write(BASE, 4'b0011, 32'h0100);
    chk_rd_mask("R5 w1c bit8", BASE, 32'hFFFE, 32'h0);
    chk_sci("R10 sci drops on clear", 1'b0);
    // event and clear of the same bit in one cycle
    @(negedge clk);
    rtc = 1'b1; addr = BASE; be = 4'b0011; wdata = 32'h0400; wr = 1'b1;
    @(posedge clk); #1 rtc = 1'b0; wr = 1'b0;
    chk_rd_mask("R6 event beats clear", BASE, 32'hFFFE, 32'h0400);
    @(negedge clk); gbl = 1'b1; @(posedge clk); #1 gbl = 1'b0;
    chk_rd_mask("R6 gbl sets bit5", BASE, 32'hFFFE, 32'h0420);
    io_write(BASE + 16'h2, 4'b0011, 32'hFADE);
    chk_sci("R10 masked enables give no sci", 1'b0);
    io_write(BASE + 16'h2, 4'b0011, 32'h0020);
    chk_sci("R10 gbl enabled sci", 1'b1);
    io_write(BASE, 4'b0011, 32'hFFFF);
    chk_rd_mask("R5 clear all", BASE, 32'hFFFE, 32'h0);
    io_write(BASE + 16'h2, 4'b0011, 32'h0);
  endtask

  task automatic wait_flip(string tag);
    logic [31:0] v, s;
    int d;
    io_write(BASE, 4'b0011, 32'h0001);
    do begin
      io_read(BASE + 16'h8, 4'b1111, v);
      d = HALF_SPAN - int'(v % HALF_SPAN);
    end while (d < 3);
    repeat (d - 2) @(negedge clk);
    io_read(BASE, 4'b0011, s);
    chk({tag, " before flip"}, s & 32'h1, 32'h0);
    io_read(BASE, 4'b0011, s);
    chk({tag, " at flip"}, s & 32'h1, 32'h1);
  endtask

  task automatic t_timer;
    logic [31:0] v1, v2;
    io_read(BASE + 16'h8, 4'b1111, v1);
    chk("R7 timer upper zero", v1 & 32'hFFFF_F000, 32'h0);
    repeat (4) @(negedge clk);
    io_read(BASE + 16'h8, 4'b1111, v2);
    chk("R7 timer step", v2, (v1 + 32'd5) & 32'h0000_0FFF);
    io_read(BASE + 16'h28, 4'b1111, v1);
    chk("R7 timer alias read", v1, (v2 + 32'd1) & 32'h0000_0FFF);
    wait_flip("R8 flip A");
    wait_flip("R8 flip B");
    io_write(BASE + 16'h2, 4'b0011, 32'h0001);
    chk_sci("R10 timer sci", 1'b1);
    io_write(BASE, 4'b0011, 32'h0001);
    chk_sci("R10 timer sci cleared", 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_word_regs();
    t_decode();
    t_unmapped();
    t_events();
    t_timer();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule